// File: doc/BRIEF.md
# Synchronous Serial Transceiver with Edge-Enabled Bit Clock

This block sends and receives asynchronous-style character frames whose bit timing comes from an external bit clock. That clock runs at the baud rate. It never clocks a flip-flop. Every register runs on the 50 MHz system clock. The external clock passes through a synchronizer, and each of its rising edges becomes a one-cycle enable inside the system domain. The transmitter and the receiver both advance on that enable, one bit per edge.

A frame starts with a low start bit. The data bits follow, least significant first. An optional parity bit comes next, then a high stop bit. The line is high when idle.

The data width (5 to 9 bits) and the parity mode are runtime inputs, and both directions use the same settings. A host hands over bytes to send through a valid/ready handshake. Received characters come back with a one-cycle valid pulse, which carries a parity-error flag and a stop-error flag.

Top module: `usrt_xcvr`

## Requirements
- R1: After reset, `tx` is high, `tx_ready` is high and `rx_valid` is low.
- R2: Each rising edge of `bit_clk` advances each direction by exactly one bit. No edge is skipped and no edge advances a direction twice.
- R3: A transmitted frame is: a 0 start bit, then the data bits from least to most significant, then the parity bit if enabled, then a 1 stop bit. With 8 data bits and even parity, the value 0x4D produces the line sequence 0,1,0,1,1,0,0,1,0,0,1.
- R4: `tx` changes only in response to a rising-edge enable, so each bit holds for a full bit-clock period.
- R5: A word is accepted in a cycle where `tx_valid` and `tx_ready` are both high. In the next cycle `tx_ready` is low, and it stays low until the frame, including its stop bit, has completed.
- R6: `data_bits` sets the character width, from 5 to 9. Only the low `data_bits` bits of `tx_data` are sent. `rx_data` carries the received bits in its low positions and zeros above them.
- R7: `par_mode` encodes the parity setting: 0 means no parity, 1 means even, 2 means odd, and 3 is treated as no parity. The transmitted parity bit makes the total count of ones across the data and parity bits even (mode 1) or odd (mode 2).
- R8: The receiver detects a start bit as a 0 sampled on an enable while idle. It then samples one bit per enable and delivers the character with a single-cycle `rx_valid` pulse.
- R9: `rx_par_err` is high with `rx_valid` when parity is enabled and the received parity bit does not match.
- R10: `rx_stop_err` is high with `rx_valid` when the stop-bit sample is 0.
- R11: While `tx_ready` is high, `tx` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk | input | 1 | External bit clock at the baud rate |
| rx | input | 1 | Serial receive line |
| tx | output | 1 | Serial transmit line |
| data_bits | input | 4 | Character width, 5 to 9 |
| par_mode | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| tx_data | input | 9 | Word to send |
| tx_valid | input | 1 | Word offered to transmitter |
| tx_ready | output | 1 | Transmitter idle and able to take a word |
| rx_data | output | 9 | Last received character |
| rx_valid | output | 1 | One-cycle pulse on character completion |
| rx_par_err | output | 1 | Parity mismatch, valid with `rx_valid` |
| rx_stop_err | output | 1 | Stop bit sampled low, valid with `rx_valid` |

## Verification
The assertions assume that `bit_clk` stays in each level for at least a few system cycles. Under that assumption every enable is followed by a cycle without one, and `tx` can change only after an enable. They also assume that `data_bits` and `par_mode` are held steady during a frame.

The bench produces `bit_clk` with a 16-cycle period. It changes the configuration only while both directions are idle. It drives `rx` on falling edges of `bit_clk`, half a bit period away from the receiver's sampling point.

// File: rtl/usrt_xcvr.sv
module usrt_xcvr #(
  parameter int MAXW = 9,
  parameter int NW   = $clog2(MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_clk,
  input  logic            rx,
  output logic            tx,
  input  logic [NW-1:0]   data_bits,
  input  logic [1:0]      par_mode,
  input  logic [MAXW-1:0] tx_data,
  input  logic            tx_valid,
  output logic            tx_ready,
  output logic [MAXW-1:0] rx_data,
  output logic            rx_valid,
  output logic            rx_par_err,
  output logic            rx_stop_err
);
  localparam int FW = MAXW + 3;
  localparam int CW = $clog2(FW + 1);

  logic [2:0] bsync;
  logic       tick;
  always_ff @(posedge clk)
    if (!rst_n) bsync <= '1;
    else        bsync <= {bsync[1:0], bit_clk};
  assign tick = bsync[1] & ~bsync[2];

  logic          par_on, par_odd;
  logic [CW-1:0] nbits;
  assign par_on  = (par_mode == 2'd1) || (par_mode == 2'd2);
  assign par_odd = (par_mode == 2'd2);
  assign nbits   = CW'(data_bits);

  // transmit
  logic [FW-1:0] frame, tx_sh;
  logic [CW-1:0] tlen, tx_left;
  logic          tpar, tx_busy, tx_q, accept;

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    tpar     = par_odd;
    for (int i = 0; i < MAXW; i++)
      if (i < int'(data_bits)) begin
        frame[i+1] = tx_data[i];
        tpar       = tpar ^ tx_data[i];
      end
    if (par_on) frame[nbits + CW'(1)] = tpar;
    tlen = nbits + (par_on ? CW'(3) : CW'(2));
  end

  assign accept   = tx_valid & ~tx_busy;
  assign tx_ready = ~tx_busy;
  assign tx       = tx_q;

  always_ff @(posedge clk)
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_q    <= 1'b1;
      tx_sh   <= '1;
      tx_left <= '0;
    end else if (accept) begin
      tx_busy <= 1'b1;
      tx_sh   <= frame;
      tx_left <= tlen;
    end else if (tick && tx_busy) begin
      if (tx_left != '0) begin
        tx_q    <= tx_sh[0];
        tx_sh   <= {1'b1, tx_sh[FW-1:1]};
        tx_left <= tx_left - CW'(1);
      end else begin
        tx_busy <= 1'b0;
        tx_q    <= 1'b1;
      end
    end

  // receive
  logic            rx_act, rx_pacc;
  logic [CW-1:0]   rx_cnt;
  logic [MAXW-1:0] rx_sh;

  always_ff @(posedge clk)
    if (!rst_n) begin
      rx_act      <= 1'b0;
      rx_pacc     <= 1'b0;
      rx_cnt      <= '0;
      rx_sh       <= '0;
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      rx_par_err  <= 1'b0;
      rx_stop_err <= 1'b0;
    end else begin
      rx_valid    <= 1'b0;
      rx_par_err  <= 1'b0;
      rx_stop_err <= 1'b0;
      if (tick) begin
        if (!rx_act) begin
          if (!rx) begin
            rx_act  <= 1'b1;
            rx_cnt  <= '0;
            rx_sh   <= '0;
            rx_pacc <= par_odd;
          end
        end else if (rx_cnt < nbits) begin
          rx_sh[rx_cnt] <= rx;
          rx_pacc       <= rx_pacc ^ rx;
          rx_cnt        <= rx_cnt + CW'(1);
        end else if (par_on && rx_cnt == nbits) begin
          rx_pacc <= rx_pacc ^ rx;
          rx_cnt  <= rx_cnt + CW'(1);
        end else begin
          rx_act      <= 1'b0;
          rx_valid    <= 1'b1;
          rx_data     <= rx_sh;
          rx_par_err  <= par_on & rx_pacc;
          rx_stop_err <= ~rx;
        end
      end
    end

  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  p_tx_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx) |-> $past(tick));
  p_ready_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_par_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_par_err |-> rx_valid);
  p_stop_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stop_err |-> rx_valid);
  p_idle_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx);
endmodule

// File: tb/usrt_xcvr_tb.sv
`timescale 1ns/1ps
module usrt_xcvr_tb;
  logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, brx = 1'b1, loop = 1'b0;
  logic [3:0] data_bits = 4'd8;
  logic [1:0] par_mode = 2'd0;
  logic [8:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_w, tx_ready, rx_valid, rx_par_err, rx_stop_err, rx_w;
  logic [8:0] rx_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;
  initial forever begin
    repeat (8) @(negedge clk);
    bclk = ~bclk;
  end
  assign rx_w = loop ? tx_w : brx;

  usrt_xcvr u_dut (
    .clk(clk), .rst_n(rst_n), .bit_clk(bclk), .rx(rx_w), .tx(tx_w),
    .data_bits(data_bits), .par_mode(par_mode), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_par_err(rx_par_err), .rx_stop_err(rx_stop_err));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic calc_par(input logic [8:0] d, input int n, input logic [1:0] pm);
    logic p = (pm == 2'd2);
    for (int i = 0; i < n; i++) p ^= d[i];
    return p;
  endfunction

  // expected frame after start bit, in line order, packed LSB first
  function automatic logic [11:0] exp_bits(input logic [8:0] d, input int n, input logic [1:0] pm, output int len);
    logic [11:0] e = '1;
    bit pon = (pm == 2'd1) || (pm == 2'd2);
    for (int i = 0; i < n; i++) e[i] = d[i];
    if (pon) e[n] = calc_par(d, n, pm);
    len = n + (pon ? 1 : 0) + 1;
    return e;
  endfunction

  task automatic send_word(input logic [8:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R5 ready low after accept", tx_ready, 0);
  endtask

  // R2 R3 R4 R6 R7: capture a transmitted frame bit by bit
  task automatic t_tx(input logic [8:0] d, input int n, input logic [1:0] pm);
    logic [11:0] exp, got;
    int len, guard;
    bit stable_ok;
    data_bits = 4'(n); par_mode = pm;
    exp = exp_bits(d, n, pm, len);
    send_word(d);
    guard = 0;
    do begin @(negedge bclk); guard++; end while (tx_w != 1'b0 && guard < 8);
    chk(tx_w == 1'b0, "R3 start bit", tx_w, 0);
    got = '1; stable_ok = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(posedge bclk); @(negedge clk);
      if (tx_w != (i == 0 ? 1'b0 : got[i-1])) stable_ok = 1'b0;
      @(negedge bclk);
      got[i] = tx_w;
      if (i < len - 1) chk(tx_ready == 1'b0, "R5 ready low mid-frame", tx_ready, 0);
    end
    chk(got == exp, $sformatf("R2 R3 R6 R7 frame n=%0d pm=%0d", n, pm), got, exp);
    chk(stable_ok, "R4 tx held through bit period", stable_ok, 1);
    @(posedge bclk); repeat (4) @(negedge clk);
    chk(tx_ready && tx_w, "R11 idle high with ready", {tx_ready, tx_w}, 2'b11);
  endtask

  task automatic t_tx_4d;
    logic [10:0] seq = 11'b10010011010; // 0,1,0,1,1,0,0,1,0,0,1 LSB first
    logic [10:0] got;
    int guard = 0;
    data_bits = 4'd8; par_mode = 2'd1;
    send_word(9'h04D);
    do begin @(negedge bclk); guard++; end while (tx_w != 1'b0 && guard < 8);
    got[0] = tx_w;
    for (int i = 1; i < 11; i++) begin @(negedge bclk); got[i] = tx_w; end
    chk(got == seq, "R3 0x4D 8E1 sequence", got, seq);
    @(posedge bclk); repeat (4) @(negedge clk);
  endtask

  // R8 R9 R10: drive a frame into rx
  task automatic t_rx(input logic [8:0] d, input int n, input logic [1:0] pm, input bit bad_par, input bit bad_stop);
    bit pon = (pm == 2'd1) || (pm == 2'd2);
    logic [8:0] expd = d & 9'((1 << n) - 1);
    int guard;
    bit seen = 1'b0, pe = 1'b0, se = 1'b0;
    logic [8:0] got = '0;
    data_bits = 4'(n); par_mode = pm;
    @(negedge bclk); brx = 1'b0;
    for (int i = 0; i < n; i++) begin @(negedge bclk); brx = d[i]; end
    if (pon) begin @(negedge bclk); brx = calc_par(d, n, pm) ^ bad_par; end
    @(negedge bclk); brx = ~bad_stop;
    for (guard = 0; guard < 40 && !seen; guard++) begin
      @(negedge clk);
      if (rx_valid) begin seen = 1'b1; got = rx_data; pe = rx_par_err; se = rx_stop_err; end
    end
    brx = 1'b1;
    chk(seen, "R8 rx_valid pulse", seen, 1);
    @(negedge clk);
    chk(!rx_valid, "R8 rx_valid single cycle", rx_valid, 0);
    chk(got == expd, $sformatf("R8 R6 rx data n=%0d", n), got, expd);
    chk(pe == (pon & bad_par), "R9 parity error flag", pe, pon & bad_par);
    chk(se == bad_stop, "R10 stop error flag", se, bad_stop);
    repeat (2) @(negedge bclk);
  endtask

  task automatic t_loop(input logic [8:0] d, input int n, input logic [1:0] pm);
    int guard;
    bit seen = 1'b0;
    logic [8:0] got = '0;
    loop = 1'b1; data_bits = 4'(n); par_mode = pm;
    send_word(d);
    for (guard = 0; guard < 400 && !seen; guard++) begin
      @(negedge clk);
      if (rx_valid) begin seen = 1'b1; got = rx_data; end
    end
    chk(seen && got == (d & 9'((1 << n) - 1)), "R8 loopback data", got, d & 9'((1 << n) - 1));
    loop = 1'b0;
    repeat (2) @(negedge bclk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(tx_w && tx_ready && !rx_valid, "R1 reset state", {tx_w, tx_ready, rx_valid}, 3'b110);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_w && tx_ready && !rx_valid, "R1 after reset release", {tx_w, tx_ready, rx_valid}, 3'b110);
    t_tx_4d();
    t_tx(9'h0A5, 8, 2'd0);
    t_tx(9'h013, 5, 2'd2);
    t_tx(9'h1C3, 9, 2'd1);
    t_tx(9'h1FF, 6, 2'd3);
    t_tx(9'h02A, 7, 2'd2);
    t_rx(9'h04D, 8, 2'd1, 1'b0, 1'b0);
    t_rx(9'h1FF, 5, 2'd0, 1'b0, 1'b0);
    t_rx(9'h155, 9, 2'd2, 1'b0, 1'b0);
    t_rx(9'h03C, 8, 2'd1, 1'b1, 1'b0);
    t_rx(9'h011, 7, 2'd2, 1'b1, 1'b0);
    t_rx(9'h066, 8, 2'd0, 1'b0, 1'b1);
    t_loop(9'h12B, 9, 2'd1);
    t_loop(9'h017, 6, 2'd2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule